// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Interrupts

This block is a register-mapped general-purpose I/O controller for up to 32 pins. Each pin has its own configuration word. That word holds the output drive enable, the input enable, the output-buffer enable, the interrupt enable and a 3-bit trigger selector. Three shared words complete the map: a pending word with one write-1-to-clear bit per pin, a read-only word with the synchronised pad levels, and a read/write word with the output levels.

Pad inputs pass through a two-flop synchroniser. A third flop keeps the previous synchronised value so that edges can be detected. Each pin has its own trigger detector, which sets that pin's pending bit. Each pin also drives its own interrupt line, gated by the pin's interrupt enable. The register port is a plain 32-bit interface: address, write strobe and write data, with read data decoded combinationally from the address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every configuration word, the pending word and the output word read zero. Every `irq` and `pad_oe` bit is 0.
- R2: The configuration word of pin n sits at byte address 4*n (0x00 to 0x7C); address bits 1:0 are ignored. Its fields are: bit 0 output enable, bit 1 input enable, bit 2 output-buffer enable, bit 3 interrupt enable, bits 7:5 trigger code. All other bits read 0.
- R3: `pad_oe[n]` is 1 exactly when both bit 0 and bit 2 of pin n's configuration word are 1. The output word at 0x88 is read/write. `pad_out[n]` carries bit n of that word while `pad_oe[n]` is 1 and is 0 otherwise.
- R4: The word at 0x84 returns the pad levels after two-flop synchronisation, so a pad change is visible two clock edges later. Writes to 0x84 are ignored.
- R5: Trigger code 0 (high level) and code 1 (low level) set the pending bit on every cycle that the synchronised level matches. A clear has no lasting effect while the level persists.
- R6: Trigger code 2 (rising), code 3 (falling) and code 4 (either edge) set the pending bit once per qualifying edge of the synchronised input. After a clear, the bit stays 0 until the next qualifying edge.
- R7: Pending word at 0x80: writing 1 to bit n clears it and writing 0 leaves it unchanged. A detection in the same cycle as the clear wins.
- R8: `irq[n]` is 1 when pending bit n and the interrupt enable (bit 3) of pin n are both 1. A pending bit is recorded whatever the enable.
- R9: Trigger codes 5, 6 and 7 never set a pending bit.
- R10: Byte addresses 0x8C to 0xFF read zero, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables (0 = tri-state) |
| irq | output | 32 | Per-pin interrupt lines |

## Verification
On every cycle, for every pin, the assertions check four things:
- A held high level keeps the pending bit set.
- A clear with no coincident detection empties the bit.
- A pending bit never moves without a detection or a clear.
- Reserved trigger codes never raise a bit, and a configuration write with both drive enables set turns on the pad enable.

The bench's scenarios cover the rest:
- The field layout and readback of the configuration words.
- The synchroniser latency as seen at the input word.
- The selectivity of each edge type: a rising-edge pin ignores a falling edge and the reverse.
- Interrupt gating by the enable bit, and the absence of effect from writes of 0 and from unmapped addresses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int CFG_OUT_EN   = 0;
    localparam int CFG_IN_EN    = 1;
    localparam int CFG_BUF_EN   = 2;
    localparam int CFG_IRQ_EN   = 3;
    localparam int CFG_TRIG_LSB = 5;
    localparam int TRIG_W       = 3;

    typedef enum logic [TRIG_W-1:0] {
        TRIG_LVL_HI = 3'd0,
        TRIG_LVL_LO = 3'd1,
        TRIG_RISE   = 3'd2,
        TRIG_FALL   = 3'd3,
        TRIG_BOTH   = 3'd4
    } trig_e;

    typedef struct packed {
        logic [TRIG_W-1:0] trig;
        logic              irq_en;
        logic              buf_en;
        logic              in_en;
        logic              out_en;
    } pin_cfg_t;

    function automatic pin_cfg_t cfg_from_word(input logic [31:0] w);
        pin_cfg_t c;
        c.out_en = w[CFG_OUT_EN];
        c.in_en  = w[CFG_IN_EN];
        c.buf_en = w[CFG_BUF_EN];
        c.irq_en = w[CFG_IRQ_EN];
        c.trig   = w[CFG_TRIG_LSB +: TRIG_W];
        return c;
    endfunction

    function automatic logic [31:0] cfg_to_word(input pin_cfg_t c);
        logic [31:0] w;
        w = '0;
        w[CFG_OUT_EN]               = c.out_en;
        w[CFG_IN_EN]                = c.in_en;
        w[CFG_BUF_EN]               = c.buf_en;
        w[CFG_IRQ_EN]               = c.irq_en;
        w[CFG_TRIG_LSB +: TRIG_W]   = c.trig;
        return w;
    endfunction

endpackage

// File: rtl/gpio_in_stage.sv
module gpio_in_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] sync,
    output logic [W-1:0] prev
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] sync;
        logic [W-1:0] prev;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = raw;
        st_d.sync = st_q.meta;
        st_d.prev = st_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync = st_q.sync;
    assign prev = st_q.prev;

endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
    import gpio_irq_pkg::*;
(
    input  logic              cur,
    input  logic              prev,
    input  logic [TRIG_W-1:0] trig,
    output logic              hit
);

    always_comb begin
        case (trig)
            TRIG_LVL_HI: hit = cur;
            TRIG_LVL_LO: hit = !cur;
            TRIG_RISE:   hit = cur && !prev;
            TRIG_FALL:   hit = !cur && prev;
            TRIG_BOTH:   hit = cur ^ prev;
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int AW    = 8,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] irq
);

    localparam int WIDX_W = AW - 2;
    localparam int PIDX_W = $clog2(NPINS);
    localparam logic [WIDX_W-1:0] WORD_PEND = WIDX_W'(32);
    localparam logic [WIDX_W-1:0] WORD_IN   = WIDX_W'(33);
    localparam logic [WIDX_W-1:0] WORD_OUT  = WIDX_W'(34);
    localparam logic [WIDX_W-1:0] WORD_NCFG = WIDX_W'(NPINS);

    typedef struct packed {
        pin_cfg_t [NPINS-1:0] cfg;
        logic     [NPINS-1:0] pend;
        logic     [NPINS-1:0] outv;
    } regs_t;

    regs_t st_d, st_q;

    logic [WIDX_W-1:0] word_idx;
    logic [PIDX_W-1:0] pin_idx;
    logic              sel_cfg, sel_pend, sel_in, sel_out;
    logic [NPINS-1:0]  sync_v, prev_v, hit_v, clr_v;
    logic [1:0]        unused_lsb;

    assign word_idx   = bus_addr[AW-1:2];
    assign pin_idx    = bus_addr[PIDX_W+1:2];
    assign unused_lsb = bus_addr[1:0];

    assign sel_cfg  = (word_idx < WORD_NCFG);
    assign sel_pend = (word_idx == WORD_PEND);
    assign sel_in   = (word_idx == WORD_IN);
    assign sel_out  = (word_idx == WORD_OUT);

    assign clr_v = (bus_wr && sel_pend) ? bus_wdata[NPINS-1:0] : '0;

    gpio_in_stage #(.W(NPINS)) u_in_stage (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (pad_in),
        .sync (sync_v),
        .prev (prev_v)
    );

    // Next-state: register writes, then pending update with detection winning
    always_comb begin
        st_d = st_q;
        if (bus_wr && sel_cfg) begin
            st_d.cfg[pin_idx] = cfg_from_word(bus_wdata);
        end
        if (bus_wr && sel_out) begin
            st_d.outv = bus_wdata[NPINS-1:0];
        end
        st_d.pend = (st_q.pend & ~clr_v) | hit_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read decode
    always_comb begin
        bus_rdata = '0;
        if (sel_cfg) begin
            bus_rdata = DW'(cfg_to_word(st_q.cfg[pin_idx]));
        end else if (sel_pend) begin
            bus_rdata[NPINS-1:0] = st_q.pend;
        end else if (sel_in) begin
            bus_rdata[NPINS-1:0] = sync_v;
        end else if (sel_out) begin
            bus_rdata[NPINS-1:0] = st_q.outv;
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        gpio_trig_det u_det (
            .cur (sync_v[i]),
            .prev(prev_v[i]),
            .trig(st_q.cfg[i].trig),
            .hit (hit_v[i])
        );

        assign pad_oe[i]  = st_q.cfg[i].out_en && st_q.cfg[i].buf_en;
        assign pad_out[i] = pad_oe[i] && st_q.outv[i];
        assign irq[i]     = st_q.pend[i] && st_q.cfg[i].irq_en;

        // R5: a held high level keeps the pending bit set
        p_lvl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.cfg[i].trig == TRIG_LVL_HI && sync_v[i]) |=> st_q.pend[i]);

        // R9: reserved codes never raise a bit
        p_bad_trig_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (st_q.cfg[i].trig > 3'd4 && !st_q.pend[i]) |=> !st_q.pend[i]);

        // R7: a clear without coincident detection empties the bit
        p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_v[i] && !hit_v[i]) |=> !st_q.pend[i]);

        // R6: without detection or clear the bit holds
        p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr_v[i] && !hit_v[i]) |=> $stable(st_q.pend[i]));

        // R3: enabling drive and buffer turns the pad driver on
        p_oe_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && sel_cfg && pin_idx == PIDX_W'(i)
             && bus_wdata[CFG_OUT_EN] && bus_wdata[CFG_BUF_EN]) |=> pad_oe[i]);
    end

endmodule

// File: tb/test_gpio_irq_bank.sv
module test_gpio_irq_bank;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  bus_addr;
    logic        bus_wr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_bank i_gpio_irq_bank (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    typedef struct packed {
        logic [7:0]  addr;
        logic        wr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{8'h00, 1'b1, 32'hFFFF_FFFF, 32'h0000_00EF, 8'd2},  // R2 field mask
        '{8'h7C, 1'b1, 32'h0000_0045, 32'h0000_0045, 8'd2},  // R2 last pin
        '{8'h05, 1'b0, 32'h0,         32'h0000_0000, 8'd2},  // R2 pin1 untouched, lsb ignored
        '{8'h88, 1'b1, 32'hA5A5_0001, 32'hA5A5_0001, 8'd3},  // R3 output word
        '{8'h84, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'd4},  // R4 write ignored
        '{8'h8C, 1'b1, 32'h0000_1234, 32'h0000_0000, 8'd10}, // R10 unmapped
        '{8'hFC, 1'b1, 32'hFFFF_FFFF, 32'h0000_0000, 8'd10}, // R10 top address
        '{8'h00, 1'b1, 32'h0000_0000, 32'h0000_0000, 8'd2}   // R2 rewrite zero
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        #1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b0;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got %h expected %h", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; pad_in = '0;
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        rd(8'h80, d); chk("R1 pending", d, 32'h0);
        rd(8'h88, d); chk("R1 output", d, 32'h0);
        rd(8'h14, d); chk("R1 cfg5", d, 32'h0);
        chk("R1 irq", irq, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            if (VECS[k].wr) wr(VECS[k].addr, VECS[k].wdata);
            rd(VECS[k].addr, d);
            chk($sformatf("R%0d vec%0d", VECS[k].req, k), d, VECS[k].exp);
        end
        rd(8'h88, d); chk("R10 output untouched", d, 32'hA5A5_0001);

        // R3 pad drive
        chk("R3 oe pin31", pad_oe[31], 1'b1);
        chk("R3 out pin31", pad_out[31], 1'b1);
        chk("R3 out pin0 gated", pad_out[0], 1'b0);
        wr(8'h00, 32'h5);
        chk("R3 oe pin0", {pad_oe[0], pad_out[0]}, 2'b11);
        wr(8'h00, 32'h1);
        chk("R3 no buffer", {pad_oe[0], pad_out[0]}, 2'b00);

        // R4 synchroniser latency
        @(negedge clk); pad_in = 32'h5A5A_5A5A;
        @(negedge clk); #1;
        bus_addr = 8'h84; #1;
        chk("R4 one edge", bus_rdata, 32'h0);
        settle(1); bus_addr = 8'h84; #1;
        chk("R4 two edges", bus_rdata, 32'h5A5A_5A5A);
        pad_in = '0;
        settle(4);
        wr(8'h80, 32'hFFFF_FFFF);
        rd(8'h80, d); chk("R7 clear all", d, 32'h0);

        // R5 level high on pin 2 with irq enabled
        wr(8'h08, 32'h08);
        pad_in[2] = 1'b1; settle(4);
        rd(8'h80, d); chk("R5 level high set", d & 32'h4, 32'h4);
        chk("R8 irq2", irq[2], 1'b1);
        wr(8'h80, 32'h4);
        rd(8'h80, d); chk("R5 clear ineffective", d & 32'h4, 32'h4);
        pad_in[2] = 1'b0; settle(4);
        wr(8'h80, 32'h4);
        rd(8'h80, d); chk("R5 cleared after release", d & 32'h4, 32'h0);

        // R5 level low on pin 3, irq disabled (R8 gating)
        wr(8'h0C, 32'h20);
        settle(2);
        rd(8'h80, d); chk("R5 level low set", d & 32'h8, 32'h8);
        chk("R8 irq3 gated", irq[3], 1'b0);
        pad_in[3] = 1'b1; settle(4);
        wr(8'h80, 32'h8);
        rd(8'h80, d); chk("R5 low released", d & 32'h8, 32'h0);

        // R6 edges on pins 4, 5, 6; R9 reserved codes on pins 7, 8
        wr(8'h10, 32'h48);
        wr(8'h14, 32'h60);
        wr(8'h18, 32'h80);
        wr(8'h1C, 32'hA0);
        wr(8'h20, 32'hE0);
        settle(3);
        rd(8'h80, d); chk("R6 no spurious", d & 32'h1F0, 32'h0);
        pad_in[8:4] = 5'h1F; settle(4);
        rd(8'h80, d); chk("R6 rise sets 4 and 6 only", d & 32'h1F0, 32'h050);
        chk("R8 irq4", irq[4], 1'b1);
        wr(8'h80, 32'h50);
        settle(3);
        rd(8'h80, d); chk("R6 stays clear", d & 32'h1F0, 32'h0);
        pad_in[8:4] = 5'h00; settle(4);
        rd(8'h80, d); chk("R6 fall sets 5 and 6 only", d & 32'h1F0, 32'h060);
        chk("R9 reserved codes", d & 32'h180, 32'h0);
        wr(8'h80, 32'h0);
        rd(8'h80, d); chk("R7 write zero keeps", d & 32'h1F0, 32'h060);
        wr(8'h80, 32'h60);
        rd(8'h80, d); chk("R7 write one clears", d & 32'h1F0, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule